// File: doc/BRIEF.md
# Pushbutton Display Position Register

This block holds the horizontal and vertical picture offsets that a video timing generator uses to place the image on the screen. Four active-low direction buttons step these offsets: right and left act on the horizontal offset, and down and up act on the vertical offset. Each button idles high through a pull-up. A press pulls the button low, and the step is applied when the button is released.

Each button passes through a synchronizer and a low-time qualifier. The qualifier counts system clock cycles while the button is low. A release counts only if the low phase lasted at least `MIN_LOW_CYC` cycles, so glitches and very short pulses cause no step. When two opposing buttons release in the same cycle, the axis they share keeps its value. Each offset is clamped to its own limits and never wraps. After reset both offsets hold their initial values, which default to the centred picture.

The offsets are plain control outputs and carry no handshake. The downstream timing generator samples them whenever it needs them. No data stream passes through this block, so there is no back-pressure.

Top module: `disp_pos_ctrl`

## Requirements
- R1: During and after reset, `h_ofs` equals `H_INIT` and `v_ofs` equals `V_INIT`. Both default to 0, the centred position.
- R2: A qualified release of `btn_right_n` adds `STEP` (default 4) to `h_ofs`.
- R3: A qualified release of `btn_left_n` subtracts `STEP` from `h_ofs`.
- R4: A qualified release of `btn_down_n` adds `STEP` to `v_ofs`. A qualified release of `btn_up_n` subtracts `STEP` from `v_ofs`.
- R5: While a button is held low, no offset changes. The step is applied only on the low-to-high transition.
- R6: A low phase shorter than `MIN_LOW_CYC` system clock cycles (default 4) leaves both offsets unchanged.
- R7: A low phase of exactly `MIN_LOW_CYC` cycles is qualified and produces a step.
- R8: If qualified releases of left and right, or of up and down, occur in the same clock cycle, the offset of that axis keeps its value.
- R9: Offsets saturate and never wrap. `h_ofs` stays within `H_MIN`..`H_MAX` (defaults -42..42), and `v_ofs` stays within `V_MIN`..`V_MAX` (defaults -30..30). A step that would cross a limit lands exactly on that limit.
- R10: Releases on different axes in the same cycle are both applied.
- R11: One press gives exactly one step, however long the button is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| btn_up_n | input | 1 | Up button, active low, idle high |
| btn_down_n | input | 1 | Down button, active low, idle high |
| btn_left_n | input | 1 | Left button, active low, idle high |
| btn_right_n | input | 1 | Right button, active low, idle high |
| h_ofs | output | OFS_W | Signed horizontal offset (two's complement) |
| v_ofs | output | OFS_W | Signed vertical offset (two's complement) |

## Verification
The two functions that can fall in the same cycle are the increment and the decrement of one axis, which happens when opposing buttons are released together. A step on one axis can also coincide with a step on the other axis.

The bench provokes both cases by driving the paired buttons low on the same falling clock edge and releasing them on the same edge. Both buttons then pass through identical synchronizer stages and qualify in the same cycle. The opposing pair is judged correct if the offset is unchanged. The cross-axis pair is judged correct if both offsets moved by one step.

// File: rtl/disp_pos_pkg.sv
package disp_pos_pkg;
  localparam int NUM_DIRS = 4;

  typedef enum logic [1:0] {
    DIR_UP    = 2'd0,
    DIR_DOWN  = 2'd1,
    DIR_LEFT  = 2'd2,
    DIR_RIGHT = 2'd3
  } dir_e;
endpackage

// File: rtl/btn_release_qual.sv
module btn_release_qual #(
  parameter int SYNC_STAGES = 2,
  parameter int MIN_LOW_CYC = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic btn_n,
  output logic release_p
);
  localparam int CW = $clog2(MIN_LOW_CYC + 1);
  localparam logic [CW-1:0] CNT_MAX = CW'(MIN_LOW_CYC);

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   lvl_d;
  logic [CW-1:0]          low_cnt;
  logic                   lvl;

  assign lvl = sync_q[SYNC_STAGES-1];

  // Synchronizer stages reset to the idle (high) level.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '1;
      lvl_d  <= 1'b1;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], btn_n};
      lvl_d  <= lvl;
    end
  end

  // Count the cycles of the low phase; the count stops at the threshold.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      low_cnt <= '0;
    end else if (lvl) begin
      low_cnt <= '0;
    end else if (low_cnt != CNT_MAX) begin
      low_cnt <= low_cnt + 1'b1;
    end
  end

  // A release counts only after a low phase of at least MIN_LOW_CYC cycles.
  assign release_p = lvl && !lvl_d && (low_cnt >= CNT_MAX);

  // R11
  single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    release_p |=> !release_p);

  // R5
  release_needs_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    release_p |=> lvl_d);
endmodule

// File: rtl/pos_axis.sv
module pos_axis #(
  parameter int W    = 10,
  parameter int STEP = 4,
  parameter int LO   = -42,
  parameter int HI   = 42,
  parameter int INIT = 0
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                inc,
  input  logic                dec,
  output logic signed [W-1:0] pos
);
  localparam int XW = W + 2;
  localparam logic signed [XW-1:0] STEP_X = XW'(STEP);
  localparam logic signed [XW-1:0] LO_X   = XW'(LO);
  localparam logic signed [XW-1:0] HI_X   = XW'(HI);
  localparam logic signed [W-1:0]  LO_W   = W'(LO);
  localparam logic signed [W-1:0]  HI_W   = W'(HI);
  localparam logic signed [W-1:0]  INIT_W = W'(INIT);

  logic signed [XW-1:0] pos_x, up_x, dn_x;
  logic signed [W-1:0]  nxt;

  // Work in a wider signed format so the limit compare cannot overflow.
  always_comb begin
    pos_x = XW'(pos);
    up_x  = pos_x + STEP_X;
    dn_x  = pos_x - STEP_X;
    nxt   = pos;
    if (inc && !dec) begin
      nxt = (up_x > HI_X) ? HI_W : W'(up_x);
    end else if (dec && !inc) begin
      nxt = (dn_x < LO_X) ? LO_W : W'(dn_x);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pos <= INIT_W;
    else        pos <= nxt;
  end

  // R8
  conflict_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && dec) |=> $stable(pos));

  // R5
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!inc && !dec) |=> $stable(pos));

  // R9
  range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pos >= LO_W) && (pos <= HI_W));

  // R2
  inc_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && !dec) |=> (pos >= $past(pos)));

  // R3
  dec_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dec && !inc) |=> (pos <= $past(pos)));
endmodule

// File: rtl/disp_pos_ctrl.sv
module disp_pos_ctrl
  import disp_pos_pkg::*;
#(
  parameter int OFS_W       = 10,
  parameter int STEP        = 4,
  parameter int SYNC_STAGES = 2,
  parameter int MIN_LOW_CYC = 4,
  parameter int H_MIN       = -42,
  parameter int H_MAX       = 42,
  parameter int V_MIN       = -30,
  parameter int V_MAX       = 30,
  parameter int H_INIT      = 0,
  parameter int V_INIT      = 0
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    btn_up_n,
  input  logic                    btn_down_n,
  input  logic                    btn_left_n,
  input  logic                    btn_right_n,
  output logic signed [OFS_W-1:0] h_ofs,
  output logic signed [OFS_W-1:0] v_ofs
);
  logic [NUM_DIRS-1:0] btn_vec;
  logic [NUM_DIRS-1:0] rel;

  assign btn_vec[DIR_UP]    = btn_up_n;
  assign btn_vec[DIR_DOWN]  = btn_down_n;
  assign btn_vec[DIR_LEFT]  = btn_left_n;
  assign btn_vec[DIR_RIGHT] = btn_right_n;

  for (genvar i = 0; i < NUM_DIRS; i++) begin : g_btn
    btn_release_qual #(
      .SYNC_STAGES(SYNC_STAGES),
      .MIN_LOW_CYC(MIN_LOW_CYC)
    ) u_qual (
      .clk      (clk),
      .rst_n    (rst_n),
      .btn_n    (btn_vec[i]),
      .release_p(rel[i])
    );
  end

  pos_axis #(
    .W(OFS_W), .STEP(STEP), .LO(H_MIN), .HI(H_MAX), .INIT(H_INIT)
  ) u_h_axis (
    .clk  (clk),
    .rst_n(rst_n),
    .inc  (rel[DIR_RIGHT]),
    .dec  (rel[DIR_LEFT]),
    .pos  (h_ofs)
  );

  pos_axis #(
    .W(OFS_W), .STEP(STEP), .LO(V_MIN), .HI(V_MAX), .INIT(V_INIT)
  ) u_v_axis (
    .clk  (clk),
    .rst_n(rst_n),
    .inc  (rel[DIR_DOWN]),
    .dec  (rel[DIR_UP]),
    .pos  (v_ofs)
  );

  // R10
  cross_axis_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rel[DIR_RIGHT] && !rel[DIR_LEFT] && rel[DIR_DOWN] && !rel[DIR_UP])
      |=> (h_ofs != $past(h_ofs) || $past(h_ofs) == OFS_W'(H_MAX))
       && (v_ofs != $past(v_ofs) || $past(v_ofs) == OFS_W'(V_MAX)));
endmodule

// File: tb/tb_disp_pos_ctrl.sv
module tb_disp_pos_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int MINC = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic up_n = 1'b1, down_n = 1'b1, left_n = 1'b1, right_n = 1'b1;
  logic signed [9:0] h_ofs, v_ofs;
  int total = 0;
  int bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  disp_pos_ctrl dut (
    .clk(clk), .rst_n(rst_n),
    .btn_up_n(up_n), .btn_down_n(down_n),
    .btn_left_n(left_n), .btn_right_n(right_n),
    .h_ofs(h_ofs), .v_ofs(v_ofs)
  );

  task automatic check(input string req, input int eh, input int ev);
    total++;
    if (int'(h_ofs) != eh || int'(v_ofs) != ev) begin
      bad++;
      $display("FAIL %s: h=%0d v=%0d expected h=%0d v=%0d", req,
               int'(h_ofs), int'(v_ofs), eh, ev);
    end
  endtask

  // mask bits: 0 up, 1 down, 2 left, 3 right
  task automatic drive(input logic [3:0] mask, input logic lvl);
    if (mask[0]) up_n = lvl;
    if (mask[1]) down_n = lvl;
    if (mask[2]) left_n = lvl;
    if (mask[3]) right_n = lvl;
  endtask

  task automatic press(input logic [3:0] mask, input int low_cyc);
    @(negedge clk);
    drive(mask, 1'b0);
    repeat (low_cyc) @(negedge clk);
    drive(mask, 1'b1);
    repeat (6) @(negedge clk);
  endtask

  task automatic t_reset();
    @(negedge clk);
    check("R1 during reset", 0, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 after reset", 0, 0);
  endtask

  task automatic t_right();
    press(4'b1000, 5);
    check("R2 right step", 4, 0);
  endtask

  task automatic t_hold_left();
    @(negedge clk);
    left_n = 1'b0;
    repeat (20) @(negedge clk);
    check("R5 held low no change", 4, 0);
    left_n = 1'b1;
    repeat (6) @(negedge clk);
    check("R3 left step, R11 single step", 0, 0);
  endtask

  task automatic t_qualify();
    press(4'b0010, MINC - 1);
    check("R6 short pulse ignored", 0, 0);
    press(4'b0010, 1);
    check("R6 one-cycle pulse ignored", 0, 0);
    press(4'b0010, MINC);
    check("R7 exact threshold counts (down)", 0, 4);
    press(4'b0001, 7);
    check("R4 up step", 0, 0);
    press(4'b0010, 9);
    check("R4 down step", 0, 4);
  endtask

  task automatic t_conflict();
    press(4'b1100, 6);
    check("R8 left+right rejected", 0, 4);
    press(4'b0011, 6);
    check("R8 up+down rejected", 0, 4);
  endtask

  task automatic t_cross();
    press(4'b1001, 6);
    check("R10 right+up both applied", 4, 0);
    press(4'b0110, 5);
    check("R10 left+down both applied", 0, 4);
  endtask

  task automatic t_saturate();
    for (int i = 0; i < 14; i++) press(4'b1000, 5);
    check("R9 h clamps at max", 42, 4);
    for (int i = 0; i < 30; i++) press(4'b0100, 5);
    check("R9 h clamps at min", -42, 4);
    for (int i = 0; i < 12; i++) press(4'b0001, 5);
    check("R9 v clamps at min", -42, -30);
    for (int i = 0; i < 20; i++) press(4'b0010, 5);
    check("R9 v clamps at max", -42, 30);
    press(4'b0001, 5);
    check("R9 step off limit", -42, 26);
  endtask

  initial begin
    t_reset();
    t_right();
    t_hold_left();
    t_qualify();
    t_conflict();
    t_cross();
    t_saturate();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    total++;
    bad++;
    $display("FAIL watchdog: run hung, actual=timeout expected=completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule